// File: doc/BRIEF.md
# Link Buffer Flow Control (Credit or On/Off)

This block holds both ends of the buffer flow control for one link that carries several virtual channels (VCs). The sending end keeps one counter per VC. Each counter holds how many flit slots are still free in the receiving buffer. A flit leaving on a VC uses up one slot. A credit coming back for that VC gives one slot back. A VC is allowed to send only while its count is above zero. The receiving end watches flits entering and leaving its per-VC buffer. Each time a flit leaves the buffer, it sends back a one-cycle credit pulse tagged with that VC's index.

A mode parameter can replace counting with on/off signalling. In this mode the receiving end keeps an occupancy level per VC. It raises a per-VC stop line when the level climbs to the buffer depth minus the round-trip latency in flits. It drops the line only when the level has fallen to a lower on-level, which gives hysteresis. The sending end then obeys the stop lines it receives and keeps no counters. This needs fewer counters and less return traffic, but the headroom above the off-level stays mostly empty.

The buffer depth must be at least the round-trip latency plus the hysteresis gap plus one. With that depth, a VC that is streaming continuously is never throttled by credits still in flight. The link wires, the latency between the two ends and the flit storage are outside this block.

Top module: `link_flow_ctrl`

## Requirements
- R1: During and after reset, every credit counter holds DEPTH, so every bit of `snd_ok` is 1 in credit mode. Also after reset, `crd_out_valid`, every bit of `stop_out`, `up_err` and `dn_err` are all 0.
- R2: In credit mode, a send (`snd_valid` with VC index `snd_vc`, binary, 0 to NUM_VC-1) lowers that VC's counter by one. A returned credit (`crd_in_valid`, `crd_in_vc`) raises it by one. Bit v of `snd_ok` is 1 exactly when VC v's counter is above zero, and the counter never exceeds DEPTH.
- R3: A send and a credit on the same VC in the same cycle leave that counter unchanged and raise no error, even when the counter is at 0.
- R4: In credit mode, two events are errors: a send on a VC whose counter is 0 with no credit for that VC in the same cycle, and a credit for a VC whose counter is DEPTH with no send on that VC. Either one leaves the counter unchanged and sets `up_err` on the next cycle. `up_err` then stays 1 until reset.
- R5: In credit mode, a buffered flit leaving (`deq_valid`, `deq_vc`) in cycle t makes `crd_out_valid` 1 in cycle t+1, with `crd_out_vc` equal to the departing VC. `crd_out_valid` is 0 in every other cycle.
- R6: In on/off mode, the receiving end tracks each VC's occupancy: `enq_valid` adds one and `deq_valid` removes one, for the VC named by `enq_vc` or `deq_vc`. Bit v of `stop_out` becomes 1 in the cycle after VC v's occupancy reaches DEPTH-RTT or more. It becomes 0 in the cycle after the occupancy falls to DEPTH-RTT-ON_GAP or less. Between those two levels it keeps its value.
- R7: In on/off mode, bit v of `snd_ok` equals the inverse of bit v of `stop_in` in the same cycle. Returned credits are ignored, and `up_err` and `crd_out_valid` stay 0.
- R8: In credit mode, `stop_in` has no effect on `snd_ok`, and `stop_out` stays all 0.
- R9: In either mode, two events on the receiving end are errors: a flit entering a VC whose occupancy is DEPTH with no departure on that VC, and a flit leaving a VC whose occupancy is 0 with no arrival on that VC. Either one leaves the occupancy unchanged and sets `dn_err` on the next cycle. `dn_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snd_valid | input | 1 | A flit is sent upstream this cycle |
| snd_vc | input | VC_W | VC of the sent flit |
| crd_in_valid | input | 1 | A credit returns to the upstream side |
| crd_in_vc | input | VC_W | VC of the returned credit |
| stop_in | input | NUM_VC | Per-VC stop lines received in on/off mode |
| snd_ok | output | NUM_VC | Per-VC send enable |
| up_err | output | 1 | Sticky counter overflow or underflow flag |
| enq_valid | input | 1 | A flit enters the downstream buffer |
| enq_vc | input | VC_W | VC of the entering flit |
| deq_valid | input | 1 | A buffered flit leaves downstream |
| deq_vc | input | VC_W | VC of the departing flit |
| crd_out_valid | output | 1 | Credit pulse toward upstream |
| crd_out_vc | output | VC_W | VC of the credit pulse |
| stop_out | output | NUM_VC | Per-VC stop lines toward upstream |
| dn_err | output | 1 | Sticky occupancy overflow or underflow flag |

## Verification
The bench runs two copies of the block side by side, one in each mode, and drives both with the same pseudo-random traffic. A bench-side arithmetic model predicts every output on every cycle. The most important corner case is a send and a credit arriving together on a drained VC. A counter that gives priority to either event would either flag a false underflow or open `snd_ok` with no real slot behind it. The bench also steps occupancy across both hysteresis levels in each direction. A design that compares against only one level would toggle `stop_out` on every flit near the threshold, and an off-by-one in a level shows up as a stop one flit early or late. Deliberate overruns at count 0 and at DEPTH check two things: that the error flag is sticky, and that the count saturates instead of wrapping. A wrapping counter would reopen `snd_ok` at once.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic {
        FC_CREDIT = 1'b0,
        FC_ONOFF  = 1'b1
    } fc_mode_e;

    localparam int LVL_W = 16;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t val;
        logic bad;
    } lvl_step_t;

    // One bounded up/down step. Simultaneous up and down cancel out.
    // An illegal step keeps the old value and reports it.
    function automatic lvl_step_t lvl_step(lvl_t cur, logic up, logic dn, lvl_t lim);
        lvl_step_t r;
        r.val = cur;
        r.bad = 1'b0;
        if (up && !dn) begin
            if (cur >= lim) r.bad = 1'b1;
            else            r.val = cur + lvl_t'(1);
        end else if (dn && !up) begin
            if (cur == '0)  r.bad = 1'b1;
            else            r.val = cur - lvl_t'(1);
        end
        return r;
    endfunction

    // Two-level comparator with memory between the levels.
    function automatic logic hyst_next(lvl_t lvl, logic cur, lvl_t hi, lvl_t lo);
        logic n;
        if (lvl >= hi)      n = 1'b1;
        else if (lvl <= lo) n = 1'b0;
        else                n = cur;
        return n;
    endfunction

endpackage

// File: rtl/lfc_credit_counter.sv
module lfc_credit_counter #(
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic         give,
    output logic         can_send,
    output lfc_pkg::lvl_t level,
    output logic         bad
);
    import lfc_pkg::*;

    lvl_t      cnt_q;
    lvl_step_t nxt;

    always_comb begin
        nxt = lvl_step(cnt_q, give, take, lvl_t'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= lvl_t'(DEPTH);
        else     cnt_q <= nxt.val;
    end

    assign can_send = (cnt_q != '0);
    assign level    = cnt_q;
    assign bad      = nxt.bad && !rst;
endmodule

// File: rtl/lfc_occ_tracker.sv
module lfc_occ_tracker #(
    parameter int DEPTH   = 8,
    parameter int OFF_LVL = 5,
    parameter int ON_LVL  = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    output logic         stop,
    output lfc_pkg::lvl_t level,
    output logic         bad
);
    import lfc_pkg::*;

    lvl_t      occ_q;
    logic      stop_q;
    lvl_step_t nxt;

    always_comb begin
        nxt = lvl_step(occ_q, push, pop, lvl_t'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q  <= '0;
            stop_q <= 1'b0;
        end else begin
            occ_q  <= nxt.val;
            stop_q <= hyst_next(nxt.val, stop_q, lvl_t'(OFF_LVL), lvl_t'(ON_LVL));
        end
    end

    assign stop  = stop_q;
    assign level = occ_q;
    assign bad   = nxt.bad && !rst;
endmodule

// File: rtl/lfc_credit_return.sv
module lfc_credit_return #(
    parameter int VC_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            deq_valid,
    input  logic [VC_W-1:0] deq_vc,
    output logic            crd_valid,
    output logic [VC_W-1:0] crd_vc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crd_valid <= 1'b0;
            crd_vc    <= '0;
        end else begin
            crd_valid <= deq_valid;
            if (deq_valid) crd_vc <= deq_vc;
        end
    end
endmodule

// File: rtl/link_flow_ctrl.sv
module link_flow_ctrl #(
    parameter int                NUM_VC = 4,
    parameter int                DEPTH  = 8,
    parameter int                RTT    = 3,
    parameter int                ON_GAP = 2,
    parameter lfc_pkg::fc_mode_e MODE   = lfc_pkg::FC_CREDIT,
    localparam int               VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snd_valid,
    input  logic [VC_W-1:0]   snd_vc,
    input  logic              crd_in_valid,
    input  logic [VC_W-1:0]   crd_in_vc,
    input  logic [NUM_VC-1:0] stop_in,
    output logic [NUM_VC-1:0] snd_ok,
    output logic              up_err,
    input  logic              enq_valid,
    input  logic [VC_W-1:0]   enq_vc,
    input  logic              deq_valid,
    input  logic [VC_W-1:0]   deq_vc,
    output logic              crd_out_valid,
    output logic [VC_W-1:0]   crd_out_vc,
    output logic [NUM_VC-1:0] stop_out,
    output logic              dn_err
);
    import lfc_pkg::*;

    localparam int OFF_LVL = DEPTH - RTT;
    localparam int ON_LVL  = OFF_LVL - ON_GAP;

    logic [NUM_VC-1:0] take_v, give_v, push_v, pop_v;
    logic [NUM_VC-1:0] up_bad_v, dn_bad_v, occ_stop_v;
    lvl_t              cnt_lvl [NUM_VC];
    lvl_t              occ_lvl [NUM_VC];
    logic              up_err_q, dn_err_q;
    logic              ret_valid;
    logic [VC_W-1:0]   ret_vc;

    // Per-VC event decode
    for (genvar v = 0; v < NUM_VC; v++) begin : g_dec
        assign take_v[v] = snd_valid    && (snd_vc    == VC_W'(v));
        assign give_v[v] = crd_in_valid && (crd_in_vc == VC_W'(v));
        assign push_v[v] = enq_valid    && (enq_vc    == VC_W'(v));
        assign pop_v[v]  = deq_valid    && (deq_vc    == VC_W'(v));
    end

    // Upstream side: counters or stop-line gating
    if (MODE == FC_CREDIT) begin : g_up_credit
        logic unused_stop_in;
        assign unused_stop_in = ^stop_in;
        for (genvar v = 0; v < NUM_VC; v++) begin : g_cnt
            lfc_credit_counter #(.DEPTH(DEPTH)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .take     (take_v[v]),
                .give     (give_v[v]),
                .can_send (snd_ok[v]),
                .level    (cnt_lvl[v]),
                .bad      (up_bad_v[v])
            );
        end
    end else begin : g_up_onoff
        logic unused_credit;
        assign unused_credit = ^{give_v, take_v};
        assign snd_ok   = ~stop_in;
        assign up_bad_v = '0;
        for (genvar v = 0; v < NUM_VC; v++) begin : g_zero
            assign cnt_lvl[v] = '0;
        end
    end

    // Downstream side: occupancy in both modes (error detection), stop in on/off
    for (genvar v = 0; v < NUM_VC; v++) begin : g_occ
        lfc_occ_tracker #(
            .DEPTH   (DEPTH),
            .OFF_LVL (OFF_LVL),
            .ON_LVL  (ON_LVL)
        ) u_occ (
            .clk   (clk),
            .rst   (rst),
            .push  (push_v[v]),
            .pop   (pop_v[v]),
            .stop  (occ_stop_v[v]),
            .level (occ_lvl[v]),
            .bad   (dn_bad_v[v])
        );
    end

    lfc_credit_return #(.VC_W(VC_W)) u_ret (
        .clk       (clk),
        .rst       (rst),
        .deq_valid (deq_valid),
        .deq_vc    (deq_vc),
        .crd_valid (ret_valid),
        .crd_vc    (ret_vc)
    );

    if (MODE == FC_CREDIT) begin : g_dn_credit
        logic unused_dn;
        assign unused_dn = ^occ_stop_v;
        assign stop_out      = '0;
        assign crd_out_valid = ret_valid;
        assign crd_out_vc    = ret_vc;
    end else begin : g_dn_onoff
        logic unused_ret;
        assign unused_ret = ^{ret_valid, ret_vc};
        assign stop_out      = occ_stop_v;
        assign crd_out_valid = 1'b0;
        assign crd_out_vc    = '0;
    end

    // Sticky error flags
    always_ff @(posedge clk) begin
        if (rst) begin
            up_err_q <= 1'b0;
            dn_err_q <= 1'b0;
        end else begin
            up_err_q <= up_err_q | (|up_bad_v);
            dn_err_q <= dn_err_q | (|dn_bad_v);
        end
    end

    assign up_err = up_err_q;
    assign dn_err = dn_err_q;

    logic unused_lvl;
    always_comb begin
        unused_lvl = 1'b0;
        for (int v = 0; v < NUM_VC; v++) unused_lvl = unused_lvl ^ (^occ_lvl[v]);
    end

    // Flattened counter levels for the bound checker
    logic [NUM_VC-1:0][LVL_W-1:0] cnt_flat;
    for (genvar v = 0; v < NUM_VC; v++) begin : g_flat
        assign cnt_flat[v] = cnt_lvl[v];
    end

endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
    parameter int                NUM_VC = 4,
    parameter int                DEPTH  = 8,
    parameter lfc_pkg::fc_mode_e MODE   = lfc_pkg::FC_CREDIT,
    parameter int                VC_W   = 2
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              snd_valid,
    input logic [VC_W-1:0]                   snd_vc,
    input logic                              crd_in_valid,
    input logic [VC_W-1:0]                   crd_in_vc,
    input logic [NUM_VC-1:0]                 stop_in,
    input logic [NUM_VC-1:0]                 snd_ok,
    input logic                              up_err,
    input logic                              deq_valid,
    input logic [VC_W-1:0]                   deq_vc,
    input logic                              crd_out_valid,
    input logic [VC_W-1:0]                   crd_out_vc,
    input logic [NUM_VC-1:0]                 stop_out,
    input logic                              dn_err,
    input logic [NUM_VC-1:0][lfc_pkg::LVL_W-1:0] cnt_flat
);
    import lfc_pkg::*;

    localparam logic IS_CREDIT = (MODE == FC_CREDIT);

    AST_RESET_FULL: assert property (@(posedge clk) disable iff (rst)
        (IS_CREDIT && $fell(rst)) |-> (&snd_ok)); // R1

    for (genvar v = 0; v < NUM_VC; v++) begin : g_bound
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            cnt_flat[v] <= lvl_t'(DEPTH)); // R2
    end

    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        (IS_CREDIT && snd_valid && !snd_ok[snd_vc]
         && !(crd_in_valid && crd_in_vc == snd_vc)) |=> up_err); // R4

    AST_UP_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        up_err |=> up_err); // R4

    AST_CREDIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (IS_CREDIT && deq_valid) |=> (crd_out_valid && crd_out_vc == $past(deq_vc))); // R5

    AST_NO_STRAY_CREDIT: assert property (@(posedge clk) disable iff (rst)
        !deq_valid |=> !crd_out_valid); // R5

    AST_ONOFF_GATE: assert property (@(posedge clk) disable iff (rst)
        !IS_CREDIT |-> (snd_ok == ~stop_in && !up_err)); // R7

    AST_CREDIT_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        IS_CREDIT |-> (stop_out == '0)); // R8

    AST_DN_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        dn_err |=> dn_err); // R9

endmodule

bind link_flow_ctrl lfc_checker #(
    .NUM_VC (NUM_VC),
    .DEPTH  (DEPTH),
    .MODE   (MODE),
    .VC_W   (VC_W)
) u_lfc_checker (
    .clk           (clk),
    .rst           (rst),
    .snd_valid     (snd_valid),
    .snd_vc        (snd_vc),
    .crd_in_valid  (crd_in_valid),
    .crd_in_vc     (crd_in_vc),
    .stop_in       (stop_in),
    .snd_ok        (snd_ok),
    .up_err        (up_err),
    .deq_valid     (deq_valid),
    .deq_vc        (deq_vc),
    .crd_out_valid (crd_out_valid),
    .crd_out_vc    (crd_out_vc),
    .stop_out      (stop_out),
    .dn_err        (dn_err),
    .cnt_flat      (cnt_flat)
);

// File: tb/tb_link_flow_ctrl.sv
module tb_link_flow_ctrl;
    localparam int NV   = 2;
    localparam int D    = 6;
    localparam int RT   = 2;
    localparam int GAP  = 2;
    localparam int VW   = 1;
    localparam int OFFL = D - RT;        // 4
    localparam int ONL  = OFFL - GAP;    // 2

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic          snd_valid, crd_in_valid, enq_valid, deq_valid;
    logic [VW-1:0] snd_vc, crd_in_vc, enq_vc, deq_vc;
    logic [NV-1:0] stop_in;

    logic [NV-1:0] c_ok, o_ok, c_stop, o_stop;
    logic          c_uerr, o_uerr, c_derr, o_derr, c_cv, o_cv;
    logic [VW-1:0] c_cvc, o_cvc;

    link_flow_ctrl #(.NUM_VC(NV), .DEPTH(D), .RTT(RT), .ON_GAP(GAP),
                     .MODE(lfc_pkg::FC_CREDIT)) dut (
        .clk(clk), .rst(rst),
        .snd_valid(snd_valid), .snd_vc(snd_vc),
        .crd_in_valid(crd_in_valid), .crd_in_vc(crd_in_vc),
        .stop_in(stop_in), .snd_ok(c_ok), .up_err(c_uerr),
        .enq_valid(enq_valid), .enq_vc(enq_vc),
        .deq_valid(deq_valid), .deq_vc(deq_vc),
        .crd_out_valid(c_cv), .crd_out_vc(c_cvc),
        .stop_out(c_stop), .dn_err(c_derr));

    link_flow_ctrl #(.NUM_VC(NV), .DEPTH(D), .RTT(RT), .ON_GAP(GAP),
                     .MODE(lfc_pkg::FC_ONOFF)) dut_oo (
        .clk(clk), .rst(rst),
        .snd_valid(snd_valid), .snd_vc(snd_vc),
        .crd_in_valid(crd_in_valid), .crd_in_vc(crd_in_vc),
        .stop_in(stop_in), .snd_ok(o_ok), .up_err(o_uerr),
        .enq_valid(enq_valid), .enq_vc(enq_vc),
        .deq_valid(deq_valid), .deq_vc(deq_vc),
        .crd_out_valid(o_cv), .crd_out_vc(o_cvc),
        .stop_out(o_stop), .dn_err(o_derr));

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int m_cnt [NV];
    int m_occ [NV];
    bit m_stop [NV];
    bit m_uerr, m_derr, m_cv;
    int m_cvc;

    // stimulus for the next cycle
    bit sv, cv, ev, dv;
    int svc, cvc, evc, dvc;
    logic [NV-1:0] stp;
    logic [31:0] lfsr = 32'h1234_5678;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic reset_models();
        for (int v = 0; v < NV; v++) begin
            m_cnt[v] = D; m_occ[v] = 0; m_stop[v] = 0;
        end
        m_uerr = 0; m_derr = 0; m_cv = 0; m_cvc = 0;
    endtask

    task automatic clear_stim();
        sv = 0; cv = 0; ev = 0; dv = 0; svc = 0; cvc = 0; evc = 0; dvc = 0; stp = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        snd_valid = 0; crd_in_valid = 0; enq_valid = 0; deq_valid = 0;
        snd_vc = '0; crd_in_vc = '0; enq_vc = '0; deq_vc = '0; stop_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_models();
        #1;
        chk("R1", "credit snd_ok", int'(c_ok), (1 << NV) - 1);
        chk("R1", "crd_out_valid", int'(c_cv), 0);
        chk("R1", "stop_out", int'(o_stop), 0);
        chk("R1", "up_err", int'(c_uerr), 0);
        chk("R1", "dn_err", int'(c_derr), 0);
    endtask

    task automatic step(input int lvl, input bit up, input bit dn, input int lim,
                        output int nv, output bit bad);
        nv = lvl; bad = 0;
        if (up && !dn) begin
            if (lvl >= lim) bad = 1; else nv = lvl + 1;
        end else if (dn && !up) begin
            if (lvl == 0) bad = 1; else nv = lvl - 1;
        end
    endtask

    // One cycle: drive at the falling edge, check, update the model at the rising edge.
    task automatic tick();
        int nv;
        bit bad;
        @(negedge clk);
        snd_valid = sv; snd_vc = VW'(svc);
        crd_in_valid = cv; crd_in_vc = VW'(cvc);
        enq_valid = ev; enq_vc = VW'(evc);
        deq_valid = dv; deq_vc = VW'(dvc);
        stop_in = stp;
        #1;
        for (int v = 0; v < NV; v++) begin
            chk("R2", "credit snd_ok bit", int'(c_ok[v]), (m_cnt[v] != 0) ? 1 : 0);
            chk("R7", "onoff snd_ok bit", int'(o_ok[v]), stp[v] ? 0 : 1);
            chk("R6", "onoff stop_out bit", int'(o_stop[v]), int'(m_stop[v]));
        end
        chk("R8", "credit stop_out", int'(c_stop), 0);
        chk("R5", "crd_out_valid", int'(c_cv), int'(m_cv));
        if (m_cv) chk("R5", "crd_out_vc", int'(c_cvc), m_cvc);
        chk("R7", "onoff crd_out_valid", int'(o_cv), 0);
        chk("R4", "credit up_err", int'(c_uerr), int'(m_uerr));
        chk("R7", "onoff up_err", int'(o_uerr), 0);
        chk("R9", "credit dn_err", int'(c_derr), int'(m_derr));
        chk("R9", "onoff dn_err", int'(o_derr), int'(m_derr));
        @(posedge clk);
        for (int v = 0; v < NV; v++) begin
            step(m_cnt[v], cv && cvc == v, sv && svc == v, D, nv, bad);
            m_cnt[v] = nv; if (bad) m_uerr = 1;
            step(m_occ[v], ev && evc == v, dv && dvc == v, D, nv, bad);
            m_occ[v] = nv; if (bad) m_derr = 1;
            if (nv >= OFFL) m_stop[v] = 1;
            else if (nv <= ONL) m_stop[v] = 0;
        end
        m_cv = dv;
        if (dv) m_cvc = dvc;
    endtask

    task automatic rnd_legal(input int enq_bias);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        svc = int'(lfsr[7]); cvc = int'(lfsr[8]); evc = int'(lfsr[9]); dvc = int'(lfsr[10]);
        sv = lfsr[0] && (m_cnt[svc] > 0);
        cv = lfsr[1] && (m_cnt[cvc] < D);
        ev = (enq_bias ? (lfsr[2] | lfsr[3]) : (lfsr[2] & lfsr[3])) && (m_occ[evc] < D);
        dv = (enq_bias ? (lfsr[4] & lfsr[5]) : (lfsr[4] | lfsr[5])) && (m_occ[dvc] > 0);
        stp = lfsr[12:11];
    endtask

    initial begin
        clear_stim();
        reset_models();
        do_reset();

        // Drain VC0 by sends only (R2), then send and credit together at zero (R3)
        for (int i = 0; i < D; i++) begin
            clear_stim(); sv = 1; svc = 0; stp = 2'b11; tick();
        end
        clear_stim(); sv = 1; svc = 0; cv = 1; cvc = 0; tick();
        clear_stim(); tick();
        chk("R3", "VC0 send+credit at zero keeps snd_ok", int'(c_ok[0]), 0);
        chk("R3", "VC0 send+credit at zero no error", int'(c_uerr), 0);
        clear_stim(); cv = 1; cvc = 0; tick();
        clear_stim(); tick();
        chk("R2", "VC0 reopened by one credit", int'(c_ok[0]), 1);
        chk("R8", "stop_in ignored in credit mode", int'(c_ok[1]), 1);

        // Fill VC1 occupancy across the thresholds and back (R6)
        for (int i = 0; i < D; i++) begin
            clear_stim(); ev = 1; evc = 1; tick();
        end
        for (int i = 0; i < D; i++) begin
            clear_stim(); dv = 1; dvc = 1; tick();
        end
        clear_stim(); tick();

        // Random legal traffic, fill-biased then drain-biased
        for (int ph = 0; ph < 8; ph++) begin
            for (int i = 0; i < 150; i++) begin
                rnd_legal(ph % 2 == 0 ? 1 : 0); tick();
            end
        end

        // Underflow on VC1 (R4)
        do_reset();
        for (int i = 0; i < D + 1; i++) begin
            clear_stim(); sv = 1; svc = 1; tick();
        end
        for (int i = 0; i < 3; i++) begin
            clear_stim(); tick();
        end
        chk("R4", "up_err sticky after underflow", int'(c_uerr), 1);
        chk("R4", "VC1 saturated at zero", int'(c_ok[1]), 0);

        // Overflow on VC0 (R4)
        do_reset();
        clear_stim(); cv = 1; cvc = 0; tick();
        clear_stim(); tick();
        chk("R4", "up_err after overflow", int'(c_uerr), 1);

        // Downstream underflow and overflow (R9)
        do_reset();
        clear_stim(); dv = 1; dvc = 0; tick();
        clear_stim(); tick();
        chk("R9", "dn_err after underflow", int'(c_derr), 1);
        do_reset();
        for (int i = 0; i < D + 1; i++) begin
            clear_stim(); ev = 1; evc = 1; tick();
        end
        clear_stim(); tick();
        chk("R9", "dn_err after overflow", int'(o_derr), 1);
        chk("R6", "stop held at full", int'(o_stop[1]), 1);

        // Random traffic including illegal events
        do_reset();
        for (int i = 0; i < 300; i++) begin
            rnd_legal(i % 2); sv = lfsr[0]; dv = lfsr[4]; tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule